// File: doc/BRIEF.md
# Duplex-Column Binary Squarer

This block returns the square of one unsigned N-bit operand as a 2N-bit result, with no clock and no internal state. It does not treat the job as a general product. For each output column it forms a duplex term. A bit sitting at the centre of the column contributes itself, because a binary bit squared is the same bit. Each symmetric pair of bits whose positions sum to the column contributes its AND once, and that AND is counted one column to the left, which is how the doubling is done without a multiplier. A single ripple of column sums then moves the carries from the least significant column to the most significant.

When N is 2, the block is built from three gates instead of the column network. Bit 1 of that result is a constant zero. Data enters and leaves on a valid/ready pair that passes straight through the block. The output side is valid whenever the input side is valid, and the input side is ready whenever the output side is ready. Under back-pressure (in_valid high, out_ready low) the source must hold in_operand steady until the transfer completes. The block holds nothing, so a held operand keeps producing the same square.

Top module: `dpx_squarer`

## Requirements
- R1: out_square equals in_operand multiplied by itself, as an unsigned 2N-bit value, for every operand value.
- R2: out_square[0] always equals in_operand[0].
- R3: out_square[1] is always 0.
- R4: For every odd operand, out_square[2:0] equals 3'b001.
- R5: out_valid equals in_valid with no clock delay.
- R6: in_ready equals out_ready with no clock delay. While in_valid is high and out_ready is low, a held operand keeps giving the same correct square.
- R7: With N = 2, the result bits are: bit 0 = a0, bit 1 = 0, bit 2 = a1 AND NOT a0, bit 3 = a1 AND a0, where a1 is operand bit 1 and a0 is operand bit 0.
- R8: The all-ones operand gives 2^(2N) - 2^(N+1) + 1, and no carry is lost out of the top column.
- R9: An operand of 2^m gives a result with exactly one set bit, at position 2m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | The operand on in_operand is valid |
| in_ready | output | 1 | The block can accept the operand (follows out_ready) |
| in_operand | input | N | Unsigned value to square |
| out_valid | output | 1 | out_square is valid (follows in_valid) |
| out_ready | input | 1 | The sink accepts out_square |
| out_square | output | 2N | Unsigned square of in_operand |

## Verification
The block keeps no state. A wrong internal value is therefore a wrong column count or a dropped carry, and it shows on out_square in the same evaluation as the operand that provokes it. A miscounted pair corrupts its own column and every column above it that the carry reaches. A lost final carry appears only for the largest operands, which is why the all-ones operand and the powers of two are checked on their own. A crossed handshake wire shows at once on out_valid or in_ready, whatever the operand.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
  // Width of one column count plus incoming carry, enough for the widest column.
  function automatic int col_cnt_width(input int n);
    return $clog2(n) + 3;
  endfunction
endpackage

// File: rtl/dpx_column.sv
module dpx_column #(
  parameter int N  = 8,
  parameter int K  = 0,
  parameter int CW = 6
) (
  input  logic [N-1:0]  opnd,
  output logic [CW-1:0] count
);
  logic mid_bit;

  // Centre bit: a bit squared is itself, so it lands in its own column.
  generate
    if ((K % 2 == 0) && (K / 2 < N)) begin : g_mid
      assign mid_bit = opnd[K/2];
    end else begin : g_nomid
      assign mid_bit = 1'b0;
    end
  endgenerate

  // Symmetric pairs from column K-1, doubled by moving them up one column.
  always_comb begin
    count = CW'(mid_bit);
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        if (i + j == K - 1) begin
          count = count + CW'(opnd[i] & opnd[j]);
        end
      end
    end
  end
endmodule

// File: rtl/dpx_carry_chain.sv
module dpx_carry_chain #(
  parameter int N  = 8,
  parameter int CW = 6
) (
  input  logic [2*N*CW-1:0] counts,
  output logic [2*N-1:0]    sq
);
  logic [CW-1:0] carry;
  logic [CW-1:0] acc;

  // Right-to-left: keep the low bit of each column, pass the rest on.
  always_comb begin
    carry = '0;
    acc   = '0;
    sq    = '0;
    for (int k = 0; k < 2 * N; k++) begin
      acc   = counts[k*CW +: CW] + carry;
      sq[k] = acc[0];
      carry = acc >> 1;
    end
  end
endmodule

// File: rtl/dpx_two_bit.sv
module dpx_two_bit (
  input  logic [1:0] opnd,
  output logic [3:0] sq
);
  logic a0_n;

  assign a0_n  = ~opnd[0];
  assign sq[0] = opnd[0];
  assign sq[1] = 1'b0;
  assign sq[2] = ~(a0_n ? ~opnd[1] : 1'b1);
  assign sq[3] = opnd[1] & opnd[0];
endmodule

// File: rtl/dpx_squarer.sv
module dpx_squarer #(
  parameter int N = 8
) (
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N-1:0]   in_operand,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*N-1:0] out_square
);
  localparam int CW   = dpx_pkg::col_cnt_width(N);
  localparam int NCOL = 2 * N;

  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  generate
    if (N == 2) begin : g_tiny
      dpx_two_bit u_tiny (
        .opnd (in_operand),
        .sq   (out_square)
      );
    end else begin : g_cols
      logic [NCOL*CW-1:0] col_counts;
      for (genvar k = 0; k < NCOL; k++) begin : g_col
        dpx_column #(.N(N), .K(k), .CW(CW)) u_col (
          .opnd  (in_operand),
          .count (col_counts[k*CW +: CW])
        );
      end
      dpx_carry_chain #(.N(N), .CW(CW)) u_chain (
        .counts (col_counts),
        .sq     (out_square)
      );
    end
  endgenerate
endmodule

// File: rtl/dpx_squarer_chk.sv
module dpx_squarer_chk #(
  parameter int N = 8
) (
  input logic           in_valid,
  input logic           in_ready,
  input logic [N-1:0]   in_operand,
  input logic           out_valid,
  input logic           out_ready,
  input logic [2*N-1:0] out_square
);
  logic [2*N-1:0] ref_sq;
  assign ref_sq = {{N{1'b0}}, in_operand} * {{N{1'b0}}, in_operand};

  always_comb begin
    if (!$isunknown({in_operand, out_square})) begin
      AST_SQUARE_EXACT: assert (out_square == ref_sq) else $error("square mismatch"); // R1
      AST_LSB_FOLLOWS: assert (out_square[0] == in_operand[0]) else $error("lsb"); // R2
      AST_BIT1_ZERO: assert (out_square[1] == 1'b0) else $error("bit1"); // R3
      if (in_operand[0]) begin
        AST_ODD_LOW3: assert (out_square[2:0] == 3'b001) else $error("odd low bits"); // R4
      end
    end
    if (!$isunknown({in_valid, out_valid})) begin
      AST_VALID_PASS: assert (out_valid == in_valid) else $error("valid"); // R5
    end
    if (!$isunknown({in_ready, out_ready})) begin
      AST_READY_PASS: assert (in_ready == out_ready) else $error("ready"); // R6
    end
  end
endmodule

bind dpx_squarer dpx_squarer_chk #(.N(N)) u_chk (
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_operand (in_operand),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_square (out_square)
);

// File: tb/dpx_squarer_test.sv
module dpx_squarer_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        v8, r8, ov8, or8;
  logic [7:0]  x8;
  logic [15:0] s8;
  logic        v2, r2, ov2, or2;
  logic [1:0]  x2;
  logic [3:0]  s2;
  logic        v16, r16, ov16, or16;
  logic [15:0] x16;
  logic [31:0] s16;

  dpx_squarer #(.N(8)) uut (.in_valid(v8), .in_ready(r8), .in_operand(x8),
    .out_valid(ov8), .out_ready(or8), .out_square(s8));
  dpx_squarer #(.N(2)) uut_w2 (.in_valid(v2), .in_ready(r2), .in_operand(x2),
    .out_valid(ov2), .out_ready(or2), .out_square(s2));
  dpx_squarer #(.N(16)) uut_w16 (.in_valid(v16), .in_ready(r16), .in_operand(x16),
    .out_valid(ov16), .out_ready(or16), .out_square(s16));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle;
    @(negedge clk);
    #1;
  endtask

  task automatic t_idle;
    v8 = 0; or8 = 0; x8 = 0; settle();
    check("R5 idle valid", 32'(ov8), 0);
    check("R6 idle ready", 32'(r8), 0);
    check("R1 zero", 32'(s8), 0);
  endtask

  task automatic t_exhaustive8;
    v8 = 1; or8 = 1;
    for (int v = 0; v < 256; v++) begin
      x8 = 8'(v); settle();
      check("R1 n8", 32'(s8), 32'(v * v));
      check("R2 lsb", 32'(s8[0]), 32'(v % 2));
      check("R3 bit1", 32'(s8[1]), 0);
      if (v % 2 == 1) check("R4 odd", 32'(s8[2:0]), 1);
    end
  endtask

  task automatic t_width2;
    v2 = 1; or2 = 1;
    for (int v = 0; v < 4; v++) begin
      x2 = 2'(v); settle();
      check("R7 bit2", 32'(s2[2]), 32'(x2[1] & ~x2[0]));
      check("R7 bit3", 32'(s2[3]), 32'(x2[1] & x2[0]));
      check("R1 n2", 32'(s2), 32'(v * v));
      check("R3 n2 bit1", 32'(s2[1]), 0);
    end
  endtask

  task automatic t_corners;
    x8 = 8'hFF; settle();
    check("R8 n8 max", 32'(s8), 32'(65536 - 512 + 1));
    x16 = 16'hFFFF; settle();
    check("R8 n16 max", s16, 32'hFFFE0001);
    for (int m = 0; m < 16; m++) begin
      x16 = 16'(1) << m; settle();
      check("R9 pow2", s16, 32'(1) << (2 * m));
    end
  endtask

  task automatic t_handshake;
    v8 = 1; or8 = 0; x8 = 8'd201; settle();
    check("R5 valid pass", 32'(ov8), 1);
    check("R6 stall ready", 32'(r8), 0);
    check("R6 held value", 32'(s8), 32'(201 * 201));
    settle();
    check("R6 held again", 32'(s8), 32'(201 * 201));
    or8 = 1; settle();
    check("R6 ready pass", 32'(r8), 1);
    v8 = 0; settle();
    check("R5 valid low", 32'(ov8), 0);
  endtask

  task automatic t_random16;
    v16 = 1; or16 = 1;
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] e;
      x16 = 16'($urandom);
      e = {16'd0, x16} * {16'd0, x16};
      settle();
      check("R1 n16", s16, e);
    end
  endtask

  initial begin
    v2 = 0; or2 = 0; x2 = 0;
    v16 = 0; or16 = 0; x16 = 0;
    t_idle();
    t_exhaustive8();
    t_width2();
    t_corners();
    t_handshake();
    t_random16();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule